// File: doc/BRIEF.md
# HDLC Receive Byte Pool with Interrupt Flags

This block sits between the receive side of an HDLC controller and a CPU. Bytes that have passed address filtering arrive one per cycle on a write port, and the last byte of each frame carries an end marker. The block stores them in a small FIFO of eight bytes by default. The CPU takes them out through a read strobe and gets the data in a register in the cycle after the strobe.

Four sticky status flags tell the CPU what happened: a byte was stored, a frame completed, the frame in progress overflowed, and a following frame was refused. The block only opens a new frame when the FIFO is empty and the message-end flag of the previous frame has been acknowledged. A refused frame is dropped whole. A frame that overflows mid-way is flushed, and its tail is skipped up to the end marker.

The CPU clears flags by writing ones. A mask register selects which flags drive the single interrupt output.

Top module: `rx_pool`

## Requirements
- R1: Stored bytes come out in arrival order. Up to DEPTH (8) bytes are held. Read data appears on `rd_data` in the cycle after the `rd_stb` cycle.
- R2: Status bit 0 (byte available) is set in every cycle in which a byte is stored.
- R3: Status bit 1 (message end) is set when the end-marked byte of an accepted frame is stored.
- R4: The first byte of a frame is accepted only if, in that cycle, the FIFO is empty and status bit 1 is clear. Otherwise status bit 3 (following-frame overflow) is set and every byte of that frame up to its end marker is discarded.
- R5: If a byte of an accepted frame arrives while the FIFO already holds DEPTH bytes, the FIFO is emptied and status bit 2 (frame overflow) is set. The rest of the frame up to its end marker is discarded, and bit 1 is not set for that frame.
- R6: When `ack_we` is high, each status bit whose `ack_bits` bit is 1 is cleared. Bits written with 0 keep their value.
- R7: If a flag is set and acknowledged in the same cycle, it stays set.
- R8: `irq` is high exactly when some status bit is 1 and its `mask` bit is 1. The mask is written through `mask_we`, a mask bit of 1 enables that flag, and the mask resets to 0.
- R9: A read strobe while the FIFO is empty leaves `rd_data` unchanged and does not advance the read position.
- R10: After reset the status is 0, `rd_data` is 0, the FIFO is empty and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | A filtered receive byte is present |
| wr_data | input | DW | Receive byte |
| wr_last | input | 1 | This byte ends its frame |
| rd_stb | input | 1 | CPU read strobe |
| rd_data | output | DW | Last byte read, registered |
| ack_we | input | 1 | Acknowledge write enable |
| ack_bits | input | 4 | Write-1-to-clear pattern for the status |
| mask_we | input | 1 | Mask register write enable |
| mask_wdata | input | 4 | New mask value |
| status | output | 4 | Flags: 0 avail, 1 msg end, 2 frame ovf, 3 following ovf |
| irq | output | 1 | OR of the unmasked status flags |

## Verification
The assertions check the cycle-level rules on every clock:
- the FIFO count never passes DEPTH;
- no byte is stored while the FIFO is full or while a frame is being refused;
- an overflow always flushes the FIFO;
- a flag being set wins over a clear in the same cycle;
- an acknowledged flag clears, and an untouched flag holds;
- an empty read leaves the data register alone.

The bench scenarios cover what only a sequence can show:
- byte order across every legal frame length;
- frame tails being skipped after an overflow;
- a following frame being refused until both the drain and the acknowledge have happened;
- the interrupt output over every combination of status and mask.

// File: rtl/rx_pool_pkg.sv
package rx_pool_pkg;
    localparam int FLAG_N     = 4;
    localparam int FLAG_AVAIL = 0;
    localparam int FLAG_MEND  = 1;
    localparam int FLAG_FOVF  = 2;
    localparam int FLAG_NOVF  = 3;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_TAKE = 2'd1,
        FR_SKIP = 2'd2
    } frame_st_e;
endpackage

// File: rtl/rx_pool_store.sv
module rx_pool_store #(
    parameter  int DEPTH = 8,
    parameter  int DW    = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] wr_data,
    input  logic          pop_req,
    input  logic          flush,
    output logic [CW-1:0] count,
    output logic [DW-1:0] rd_data
);
    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
        logic [DW-1:0]            rdat;
    } store_t;

    store_t st_q, st_d;
    logic   pop;

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        pop  = pop_req && (st_q.cnt != '0);
        if (pop) begin
            st_d.rdat = st_q.mem[st_q.rp];
            st_d.rp   = step(st_q.rp);
        end
        if (push) begin
            st_d.mem[st_q.wp] = wr_data;
            st_d.wp           = step(st_q.wp);
        end
        if (flush) begin
            st_d.wp  = st_d.rp;
            st_d.cnt = '0;
        end else if (push && !pop) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (!push && pop) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count   = st_q.cnt;
    assign rd_data = st_q.rdat;

    // R1
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CW'(DEPTH));

    // R9
    empty_read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && st_q.cnt == '0) |=> rd_data == $past(rd_data));

    // R5
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !push) |=> st_q.cnt == '0);
endmodule

// File: rtl/rx_pool_frame.sv
module rx_pool_frame
    import rx_pool_pkg::*;
#(
    parameter  int DEPTH = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              wr_last,
    input  logic [CW-1:0]     count,
    input  logic              mend_pending,
    output logic              push,
    output logic              flush,
    output logic [FLAG_N-1:0] set_vec
);
    typedef struct packed {
        frame_st_e st;
    } ctl_t;

    ctl_t ctl_q, ctl_d;
    logic full;
    logic blocked;

    assign full    = (count == CW'(DEPTH));
    assign blocked = (count != '0) || mend_pending;

    always_comb begin
        ctl_d   = ctl_q;
        push    = 1'b0;
        flush   = 1'b0;
        set_vec = '0;
        if (wr_valid) begin
            unique case (ctl_q.st)
                FR_IDLE: begin
                    if (blocked) begin
                        set_vec[FLAG_NOVF] = 1'b1;
                        ctl_d.st = wr_last ? FR_IDLE : FR_SKIP;
                    end else begin
                        push = 1'b1;
                        set_vec[FLAG_AVAIL] = 1'b1;
                        if (wr_last) set_vec[FLAG_MEND] = 1'b1;
                        else         ctl_d.st = FR_TAKE;
                    end
                end
                FR_TAKE: begin
                    if (full) begin
                        flush = 1'b1;
                        set_vec[FLAG_FOVF] = 1'b1;
                        ctl_d.st = wr_last ? FR_IDLE : FR_SKIP;
                    end else begin
                        push = 1'b1;
                        set_vec[FLAG_AVAIL] = 1'b1;
                        if (wr_last) begin
                            set_vec[FLAG_MEND] = 1'b1;
                            ctl_d.st = FR_IDLE;
                        end
                    end
                end
                FR_SKIP: begin
                    if (wr_last) ctl_d.st = FR_IDLE;
                end
                default: ctl_d.st = FR_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: FR_IDLE};
        else        ctl_q <= ctl_d;
    end

    // R1
    no_push_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> count < CW'(DEPTH));

    // R4
    refuse_no_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[FLAG_NOVF] |-> !push);

    // R5
    ovf_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[FLAG_FOVF] |-> (flush && !push && !set_vec[FLAG_MEND]));

    // R3
    mend_with_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_vec[FLAG_MEND] |-> (push && wr_last));
endmodule

// File: rtl/rx_pool_flags.sv
module rx_pool_flags
    import rx_pool_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_N-1:0] set_vec,
    input  logic              ack_we,
    input  logic [FLAG_N-1:0] ack_bits,
    input  logic              mask_we,
    input  logic [FLAG_N-1:0] mask_wdata,
    output logic [FLAG_N-1:0] status,
    output logic              irq
);
    typedef struct packed {
        logic [FLAG_N-1:0] stat;
        logic [FLAG_N-1:0] mask;
    } flg_t;

    flg_t fl_q, fl_d;
    logic [FLAG_N-1:0] clr;

    always_comb begin
        fl_d    = fl_q;
        clr     = ack_we ? ack_bits : '0;
        fl_d.stat = (fl_q.stat & ~clr) | set_vec;
        if (mask_we) fl_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fl_q <= '0;
        else        fl_q <= fl_d;
    end

    assign status = fl_q.stat;
    assign irq    = |(fl_q.stat & fl_q.mask);

    for (genvar gi = 0; gi < FLAG_N; gi++) begin : g_chk
        // R7
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[gi] |=> status[gi]);

        // R6
        w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_we && ack_bits[gi] && !set_vec[gi]) |=> !status[gi]);

        // R6
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!set_vec[gi] && !(ack_we && ack_bits[gi])) |=> status[gi] == $past(status[gi]));
    end
endmodule

// File: rtl/rx_pool.sv
module rx_pool
    import rx_pool_pkg::*;
#(
    parameter  int DEPTH = 8,
    parameter  int DW    = 8,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          wr_last,
    input  logic          rd_stb,
    output logic [DW-1:0] rd_data,
    input  logic          ack_we,
    input  logic [3:0]    ack_bits,
    input  logic          mask_we,
    input  logic [3:0]    mask_wdata,
    output logic [3:0]    status,
    output logic          irq
);
    logic              push;
    logic              flush;
    logic [CW-1:0]     count;
    logic [FLAG_N-1:0] set_vec;

    rx_pool_frame #(.DEPTH(DEPTH)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_valid     (wr_valid),
        .wr_last      (wr_last),
        .count        (count),
        .mend_pending (status[FLAG_MEND]),
        .push         (push),
        .flush        (flush),
        .set_vec      (set_vec)
    );

    rx_pool_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .push    (push),
        .wr_data (wr_data),
        .pop_req (rd_stb),
        .flush   (flush),
        .count   (count),
        .rd_data (rd_data)
    );

    rx_pool_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_vec    (set_vec),
        .ack_we     (ack_we),
        .ack_bits   (ack_bits),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .status     (status),
        .irq        (irq)
    );
endmodule

// File: tb/rx_pool_bench.sv
module rx_pool_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_last = 1'b0;
    logic       rd_stb = 1'b0;
    logic [7:0] rd_data;
    logic       ack_we = 1'b0;
    logic [3:0] ack_bits = '0;
    logic       mask_we = 1'b0;
    logic [3:0] mask_wdata = '0;
    logic [3:0] status;
    logic       irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    rx_pool u_rx_pool (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_data(wr_data),
        .wr_last(wr_last), .rd_stb(rd_stb), .rd_data(rd_data), .ack_we(ack_we),
        .ack_bits(ack_bits), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .status(status), .irq(irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int f, input int i);
        return 8'((f * 37 + i * 11 + 3) & 255);
    endfunction

    task automatic send(input logic [7:0] d, input bit last);
        wr_valid = 1'b1; wr_data = d; wr_last = last;
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0;
    endtask

    task automatic send_frame(input int f, input int len);
        for (int i = 0; i < len; i++) send(pat(f, i), i == len - 1);
    endtask

    task automatic rd(output logic [7:0] v);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        v = rd_data;
    endtask

    task automatic ack(input logic [3:0] b);
        ack_we = 1'b1; ack_bits = b;
        @(negedge clk);
        ack_we = 1'b0; ack_bits = '0;
    endtask

    task automatic set_mask(input logic [3:0] m);
        mask_we = 1'b1; mask_wdata = m;
        @(negedge clk);
        mask_we = 1'b0;
    endtask

    task automatic read_frame(input string tag, input int f, input int len);
        logic [7:0] v;
        for (int i = 0; i < len; i++) begin
            rd(v);
            chk(tag, int'(v), int'(pat(f, i)));
        end
    endtask

    task automatic make_all_set();
        logic [7:0] v;
        rd(v);
        ack(4'hF);
        send_frame(90, 9);
        send_frame(91, 1);
        send_frame(92, 1);
        chk("R6 all flags", int'(status), 15);
    endtask

    initial begin
        logic [7:0] v;
        logic [7:0] prev;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 status", int'(status), 0);
        chk("R10 rd_data", int'(rd_data), 0);
        chk("R10 irq", int'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R9 empty read right after reset
        rd(v);
        chk("R9 empty after reset", int'(v), 0);

        // R1 R2 R3 every legal length
        for (int len = 1; len <= 8; len++) begin
            send_frame(len, len);
            chk("R2 R3 flags", int'(status), 3);
            if (len == 1) chk("R8 reset mask", int'(irq), 0);
            read_frame("R1 order", len, len);
            rd(v);
            chk("R9 empty hold", int'(v), int'(pat(len, len - 1)));
            ack(4'b0001);
            chk("R6 partial ack", int'(status), 2);
            ack(4'b0010);
            chk("R6 ack mend", int'(status), 0);
        end

        // R5 overflow for lengths past depth
        for (int len = 9; len <= 12; len++) begin
            send_frame(20 + len, len);
            chk("R5 ovf flags", int'(status), 5);
            prev = rd_data;
            rd(v);
            chk("R5 flushed empty", int'(v), int'(prev));
            ack(4'hF);
            send_frame(40 + len, 2);
            chk("R5 recover flags", int'(status), 3);
            read_frame("R5 recover data", 40 + len, 2);
            ack(4'hF);
        end

        // R4 following frame refused by data and by unacked end
        for (int l = 1; l <= 4; l++) begin
            send_frame(50 + l, l);
            send_frame(60 + l, 3);
            chk("R4 refused on data", int'(status), 11);
            read_frame("R4 first frame kept", 50 + l, l);
            prev = rd_data;
            rd(v);
            chk("R4 refused bytes absent", int'(v), int'(prev));
            ack(4'b1001);
            chk("R6 ack subset", int'(status), 2);
            send_frame(70 + l, 2);
            chk("R4 refused on unacked end", int'(status), 10);
            ack(4'hF);
            send_frame(80 + l, 2);
            chk("R4 accepted after ack", int'(status), 3);
            read_frame("R4 accepted data", 80 + l, 2);
            ack(4'hF);
        end

        // R6 R8 every status pattern against every mask
        for (int s = 0; s < 16; s++) begin
            make_all_set();
            ack(4'(~s));
            chk("R6 w1c pattern", int'(status), s);
            for (int m = 0; m < 16; m++) begin
                set_mask(4'(m));
                chk("R8 irq", int'(irq), int'((s & m) != 0));
            end
        end
        set_mask(4'h0);

        // R7 set and clear in the same cycle
        rd(v);
        ack(4'hF);
        send(8'hA5, 1'b0);
        wr_valid = 1'b1; wr_data = 8'h5A; wr_last = 1'b1;
        ack_we = 1'b1; ack_bits = 4'b0011;
        @(negedge clk);
        wr_valid = 1'b0; wr_last = 1'b0; ack_we = 1'b0; ack_bits = '0;
        chk("R7 set wins", int'(status), 3);
        rd(v);
        chk("R7 data 0", int'(v), 'hA5);
        rd(v);
        chk("R7 data 1", int'(v), 'h5A);

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule